// File: doc/BRIEF.md
# Timestamp-Replacement Fully Associative Cache

A small single-word-per-entry cache that sits between a requester and a slow backing memory. Every entry keeps a full address tag, one data word and the value of a free-running cycle counter taken at its most recent reference. A request is compared against all entries at once. A hit answers from the cache and refreshes the entry's stamp. A miss stalls the requester, evicts a victim, fetches the word over a request/valid handshake and installs it in the freed slot.

The victim is the first invalid entry if any exists. Otherwise it is the valid entry whose stamp lags the counter the most, or, when the random mode input is high, an entry picked by a linear feedback shift register. Stores are write-allocate and write-through. Each store ends with one write cycle to backing memory, so an eviction never needs a writeback.

Top module: `stamp_cache`

## Requirements
- R1: After reset every entry is invalid, `req_ready` is 1, `rsp_valid` is 0 and `mem_req` is 0.
- R2: A read accepted (`req_valid` with `req_ready` high at a rising edge) whose address matches a valid entry raises `rsp_valid` for one cycle on the next edge, with the stored word on `rsp_rdata`. It starts no memory access and leaves `req_ready` high.
- R3: A read miss drops `req_ready` and holds `mem_req`=1, `mem_we`=0, `mem_addr`=request address from the edge after acceptance until the edge at which `mem_valid` is high. On that edge the returned word is installed and appears on `rsp_rdata` with `rsp_valid`=1, and `req_ready` rises again.
- R4: A 16-bit cycle counter starts at 0 when reset ends and advances on every edge. A hit, or the completion of a fill, writes the counter value of that edge into the entry's stamp. Age is (counter − stamp) mod 2^16, so counter wrap keeps the order of entries referenced within the last 65536 cycles.
- R5: With `rand_mode`=0 and all entries valid, a miss evicts the entry with the largest age. Among equal ages the lowest index wins.
- R6: A miss with any invalid entry fills the lowest-indexed invalid entry, in either mode.
- R7: With `rand_mode`=1 and all entries valid, the victim index is the low log2(ENTRIES) bits of a 16-bit shift register. The register is seeded to 16'hACE1 at reset and shifts left on every miss, taking bit15^bit13^bit12^bit10 into bit 0. It is sampled before the shift.
- R8: A store hit writes the data into the entry at acceptance and refreshes its stamp. The next cycle is a single write cycle with `mem_req`=1, `mem_we`=1, `mem_addr`/`mem_wdata` equal to the store. At the following edge `rsp_valid` pulses with the store data on `rsp_rdata`.
- R9: A store miss first fetches the word exactly as in R3, then installs the store data in place of the fetched word. It then performs the write cycle and response of R8.
- R10: `mem_we` is high only in the write cycle that ends a store. An eviction causes no memory write.
- R11: `req_valid` while `req_ready` is low is ignored and changes neither the cache contents nor the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rand_mode | input | 1 | 1 selects the pseudo-random victim |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 for a store, 0 for a load |
| req_addr | input | AW | Request address |
| req_wdata | input | DW | Store data |
| req_ready | output | 1 | Cache can accept a request this cycle |
| rsp_valid | output | 1 | Response pulse |
| rsp_rdata | output | DW | Load data, or store data for a store |
| mem_req | output | 1 | Backing-memory access active |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Backing-memory address |
| mem_wdata | output | DW | Backing-memory write data |
| mem_valid | input | 1 | Read data returned this cycle |
| mem_rdata | input | DW | Returned read data |

## Verification
A corrupted data word shows on `rsp_rdata` one cycle after the next hit on that address. A wrong stamp, victim index or shift-register value stays hidden until the evicted address or the wrongly kept one is touched again. At that point a memory read appears where a hit was due, or the reverse, possibly many requests later. For this reason the reference model tracks every entry's stamp and validity and compares every output on every cycle. The directed sequences revisit the evicted addresses right after each replacement so that such faults show within a few requests.

// File: rtl/stamp_cache.sv
module stamp_cache #(
  parameter int ENTRIES = 4,
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int SW = 16,
  parameter logic [15:0] LFSR_SEED = 16'hACE1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rand_mode,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ready,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_valid,
  input  logic [DW-1:0] mem_rdata
);
  localparam int IW = $clog2(ENTRIES);

  typedef enum logic [1:0] {ST_IDLE, ST_FILL, ST_WRITE} st_t;
  st_t st;

  logic [AW-1:0] tag_q   [ENTRIES];
  logic [DW-1:0] data_q  [ENTRIES];
  logic [SW-1:0] stamp_q [ENTRIES];
  logic [ENTRIES-1:0] vld_q;
  logic [SW-1:0] now_q;
  logic [15:0]   lfsr_q;
  logic [AW-1:0] p_addr;
  logic [DW-1:0] p_wdata;
  logic          p_we;
  logic [IW-1:0] p_vic;

  logic [ENTRIES-1:0] match;
  logic          hit;
  logic [IW-1:0] hit_idx, inv_idx, age_vic, victim;
  logic          have_inv;
  logic [SW-1:0] age, best_age;
  logic [15:0]   lfsr_nxt;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = vld_q[g] && (tag_q[g] == req_addr);
  end

  assign hit      = |match;
  assign lfsr_nxt = {lfsr_q[14:0], lfsr_q[15] ^ lfsr_q[13] ^ lfsr_q[12] ^ lfsr_q[10]};

  always_comb begin
    hit_idx  = '0;
    inv_idx  = '0;
    have_inv = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) hit_idx = IW'(i);
      if (!vld_q[i]) begin
        have_inv = 1'b1;
        inv_idx  = IW'(i);
      end
    end
  end

  always_comb begin
    age_vic  = '0;
    best_age = '0;
    age      = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      age = now_q - stamp_q[i];
      if (i == 0 || age > best_age) begin
        best_age = age;
        age_vic  = IW'(i);
      end
    end
  end

  assign victim = have_inv ? inv_idx : (rand_mode ? lfsr_q[IW-1:0] : age_vic);

  assign req_ready = (st == ST_IDLE);
  assign mem_req   = (st != ST_IDLE);
  assign mem_we    = (st == ST_WRITE);
  assign mem_addr  = p_addr;
  assign mem_wdata = p_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      vld_q     <= '0;
      now_q     <= '0;
      lfsr_q    <= LFSR_SEED;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      p_addr    <= '0;
      p_wdata   <= '0;
      p_we      <= 1'b0;
      p_vic     <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        tag_q[i]   <= '0;
        data_q[i]  <= '0;
        stamp_q[i] <= '0;
      end
    end else begin
      now_q     <= now_q + 1'b1;
      rsp_valid <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (req_valid) begin
            p_addr  <= req_addr;
            p_wdata <= req_wdata;
            p_we    <= req_write;
            if (hit) begin
              stamp_q[hit_idx] <= now_q;
              if (req_write) begin
                data_q[hit_idx] <= req_wdata;
                st <= ST_WRITE;
              end else begin
                rsp_valid <= 1'b1;
                rsp_rdata <= data_q[hit_idx];
              end
            end else begin
              p_vic         <= victim;
              vld_q[victim] <= 1'b0;
              lfsr_q        <= lfsr_nxt;
              st            <= ST_FILL;
            end
          end
        end
        ST_FILL: begin
          if (mem_valid) begin
            tag_q[p_vic]   <= p_addr;
            vld_q[p_vic]   <= 1'b1;
            stamp_q[p_vic] <= now_q;
            data_q[p_vic]  <= p_we ? p_wdata : mem_rdata;
            if (p_we) begin
              st <= ST_WRITE;
            end else begin
              rsp_valid <= 1'b1;
              rsp_rdata <= mem_rdata;
              st        <= ST_IDLE;
            end
          end
        end
        default: begin
          rsp_valid <= 1'b1;
          rsp_rdata <= p_wdata;
          st        <= ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/stamp_cache_chk.sv
module stamp_cache_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic          mem_req,
  input logic          mem_we,
  input logic          mem_valid,
  input logic [AW-1:0] mem_addr
);
  AST_WE_INSIDE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_req); // R10
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !req_ready); // R11
  AST_FILL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && !mem_valid) |=> (mem_req && !mem_we)); // R3
  AST_FILL_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && !mem_valid) |=> $stable(mem_addr)); // R3
  AST_FILL_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && mem_valid) |=> (rsp_valid || mem_we)); // R9
  AST_WRITE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (!mem_we && rsp_valid)); // R8
endmodule

bind stamp_cache stamp_cache_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .mem_req(mem_req), .mem_we(mem_we), .mem_valid(mem_valid), .mem_addr(mem_addr)
);

// File: tb/sim_stamp_cache.sv
module sim_stamp_cache;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 4;
  localparam int AW = 16;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic rand_mode = 1'b0, req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid, mem_req, mem_we;
  logic [DW-1:0] rsp_rdata, mem_wdata;
  logic [AW-1:0] mem_addr;
  logic mem_valid = 1'b0;
  logic [DW-1:0] mem_rdata = '0;

  stamp_cache #(.ENTRIES(N), .AW(AW), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .rand_mode(rand_mode),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_valid(mem_valid), .mem_rdata(mem_rdata)
  );

  int n_run = 0, n_fail = 0;
  string tag = "R1";

  // reference model
  int m_st;
  logic [15:0] m_cnt, m_lfsr;
  logic [AW-1:0] m_tag [N];
  logic [DW-1:0] m_dat [N];
  logic [15:0]   m_stp [N];
  bit m_val [N];
  int m_vic, hit;
  logic [AW-1:0] m_addr;
  logic [DW-1:0] m_wd, e_rd;
  bit m_we, e_rsp, nr;
  logic [DW-1:0] bmem [logic [AW-1:0]];
  int wait_n = 0;

  function automatic logic [DW-1:0] mem_rd(logic [AW-1:0] a);
    if (bmem.exists(a)) return bmem[a];
    return a ^ 16'h5A5A;
  endfunction

  function automatic int pick_victim();
    int best = 0, bage = -1;
    for (int i = 0; i < N; i++) if (!m_val[i]) return i;
    if (rand_mode) return int'(m_lfsr % N);
    for (int i = 0; i < N; i++) begin
      int age = int'(16'(m_cnt - m_stp[i]));
      if (age > bage) begin bage = age; best = i; end
    end
    return best;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = '0; m_lfsr = 16'hACE1; e_rsp = 0; e_rd = '0;
      m_addr = '0; m_wd = '0; m_we = 0;
      for (int i = 0; i < N; i++) begin m_val[i] = 0; m_stp[i] = '0; end
    end else begin
      nr = 0;
      case (m_st)
        0: if (req_valid) begin
          hit = -1;
          for (int i = 0; i < N; i++) if (m_val[i] && m_tag[i] == req_addr) hit = i;
          m_addr = req_addr; m_wd = req_wdata; m_we = req_write;
          if (hit >= 0) begin
            m_stp[hit] = m_cnt;
            if (req_write) begin m_dat[hit] = req_wdata; m_st = 2; end
            else begin nr = 1; e_rd = m_dat[hit]; end
          end else begin
            m_vic = pick_victim();
            m_val[m_vic] = 0;
            m_lfsr = {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};
            m_st = 1;
          end
        end
        1: if (mem_valid) begin
          m_tag[m_vic] = m_addr; m_val[m_vic] = 1; m_stp[m_vic] = m_cnt;
          m_dat[m_vic] = m_we ? m_wd : mem_rdata;
          if (m_we) m_st = 2;
          else begin nr = 1; e_rd = mem_rdata; m_st = 0; end
        end
        default: begin bmem[m_addr] = m_wd; nr = 1; e_rd = m_wd; m_st = 0; end
      endcase
      e_rsp = nr;
      m_cnt = m_cnt + 16'd1;
    end
  end

  task automatic chk(string sig, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, sig, act, exp);
    end
  endtask

  task automatic tick();
    int lat;
    @(negedge clk);
    chk("req_ready", 32'(req_ready), 32'(m_st == 0));
    chk("mem_req",   32'(mem_req),   32'(m_st != 0));
    chk("mem_we",    32'(mem_we),    32'(m_st == 2));
    if (m_st != 0) chk("mem_addr", 32'(mem_addr), 32'(m_addr));
    if (m_st == 2) chk("mem_wdata", 32'(mem_wdata), 32'(m_wd));
    chk("rsp_valid", 32'(rsp_valid), 32'(e_rsp));
    if (e_rsp) chk("rsp_rdata", 32'(rsp_rdata), 32'(e_rd));
    if (m_st == 1) begin
      lat = int'(m_addr % 3);
      if (wait_n >= lat) begin mem_valid = 1'b1; mem_rdata = mem_rd(m_addr); end
      else begin mem_valid = 1'b0; wait_n++; end
    end else begin
      mem_valid = 1'b0; wait_n = 0;
    end
  endtask

  task automatic issue(bit we, logic [AW-1:0] a, logic [DW-1:0] d, bit noise);
    while (m_st != 0) tick();
    req_valid = 1'b1; req_write = we; req_addr = a; req_wdata = d;
    tick();
    req_valid = 1'b0;
    while (m_st != 0) begin
      if (noise) begin
        req_valid = 1'b1; req_write = 1'b1; req_addr = a ^ 16'h0F0F; req_wdata = 16'hDEAD;
      end
      tick();
      req_valid = 1'b0;
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tag = "R1";
    tick(); tick();

    tag = "R3";
    for (int i = 0; i < 4; i++) issue(0, 16'h0010 + 16'(i), '0, 0);
    tag = "R2";
    for (int i = 0; i < 4; i++) issue(0, 16'h0010 + 16'(i), '0, 0);

    tag = "R5";
    issue(0, 16'h0012, '0, 0); issue(0, 16'h0010, '0, 0);
    issue(0, 16'h0013, '0, 0); issue(0, 16'h0011, '0, 0);
    issue(0, 16'h0014, '0, 0);
    issue(0, 16'h0012, '0, 0);
    issue(0, 16'h0011, '0, 0);

    tag = "R8";
    issue(1, 16'h0013, 16'hBEEF, 0);
    issue(0, 16'h0013, '0, 0);
    tag = "R9";
    issue(1, 16'h0017, 16'h1234, 0);
    issue(0, 16'h0017, '0, 0);

    tag = "R6";
    do_reset();
    tick();
    issue(0, 16'h0020, '0, 0); issue(0, 16'h0021, '0, 0);
    issue(0, 16'h0020, '0, 0); issue(0, 16'h0022, '0, 0);
    issue(0, 16'h0023, '0, 0); issue(0, 16'h0024, '0, 0);

    tag = "R7";
    rand_mode = 1'b1;
    for (int i = 0; i < 12; i++) issue(0, 16'h0100 + 16'(i), '0, 0);
    for (int i = 0; i < 12; i++) issue(0, 16'h0100 + 16'(i), '0, 0);
    rand_mode = 1'b0;

    tag = "R11";
    for (int i = 0; i < 6; i++) issue(i[0], 16'h0200 + 16'(i % 5), 16'(i * 7), 1);
    for (int i = 0; i < 6; i++) issue(0, 16'h0200 + 16'(i % 5), '0, 0);

    tag = "R4";
    issue(0, 16'h0300, '0, 0); issue(0, 16'h0301, '0, 0);
    issue(0, 16'h0302, '0, 0); issue(0, 16'h0303, '0, 0);
    repeat (65000) tick();
    issue(0, 16'h0301, '0, 0); issue(0, 16'h0300, '0, 0);
    repeat (1000) tick();
    issue(0, 16'h0303, '0, 0);
    issue(0, 16'h0304, '0, 0);
    issue(0, 16'h0302, '0, 0);
    issue(0, 16'h0301, '0, 0);

    tag = "R10";
    for (int i = 0; i < 400; i++) begin
      rand_mode = $urandom_range(0, 3) == 0;
      issue($urandom_range(0, 2) == 0, 16'h0400 + 16'($urandom_range(0, 7)),
            16'($urandom), $urandom_range(0, 3) == 0);
    end
    tick(); tick();

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule